// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block watches the stream of qualified byte writes headed for a page-write controller. It keeps a persistent write-protection flag and tells the controller, for each write in the current cycle, whether the byte may be stored in the array. Protection is turned on by a short three-write key sequence. It is turned off by a longer six-write sequence. While protection is on, a page load is stored only when the same three-write key sequence comes right before it. Any other write still makes the controller run a full write-cycle time, but nothing is stored.

Command bytes are never stored. The block raises a suppress flag on every write that it consumes as part of a sequence. The key addresses themselves stay usable for ordinary data. Every command write must arrive within the page-load window that follows the previous write, or the partial sequence is dropped. The protection flag is cleared only by a separate factory-reset input, so a power-good reset leaves it unchanged.

Key encodings (address/data, hexadecimal):
- Lock or unlock-for-one-page: 5555/AA, 2AAA/55, 5555/A0.
- Disable protection: 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, 5555/20.

Top module: `wprot_seq`

## Requirements
- R1: After factory reset and power reset, `protOn` is 0. `commitEn` and `cmdSuppress` are 0 whenever `wrValid` is 0.
- R2: Each write that advances a sequence (5555/AA from idle, 2AAA/55 after the first key, and so on) shows `cmdSuppress`=1 and `commitEn`=0 in its own cycle.
- R3: After the lock sequence 5555/AA, 2AAA/55, 5555/A0, `protOn` stays 0 while `busy` is high. It becomes 1 on the clock edge after `busy` falls.
- R4: While `protOn`=1, a write that is not preceded by the lock sequence gives `commitEn`=0 and `cmdSuppress`=0.
- R5: After the lock sequence completes, every later write shows `commitEn`=1 until a gap longer than the window ends the page load. This holds whether protection is on or off.
- R6: The six-write disable sequence marks all six writes with `cmdSuppress`=1. `protOn` reads 0 in the cycle after the sixth write.
- R7: A write that does not match the next expected key returns the matcher to idle. That write shows `cmdSuppress`=0 and `commitEn`=!`protOn`. The writes after it must restart the sequence from the first key.
- R8: A write whose clock edge falls `WINDOW_CYC` cycles after the previous write continues a sequence. A gap of `WINDOW_CYC`+1 cycles drops the sequence first.
- R9: Asserting `rstN` alone leaves `protOn` unchanged and returns the matcher to idle. Only `factoryRstN` low clears `protOn`.
- R10: With protection off and the matcher idle, a non-key write commits (`commitEn`=1). This includes non-key data written to a key address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-good reset; clears the matcher and the pending lock |
| factoryRstN | input | 1 | Active-low reset; the only thing that clears the protection flag |
| wrValid | input | 1 | One-cycle strobe for a qualified write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data byte |
| busy | input | 1 | Controller's internal write cycle is in progress |
| protOn | output | 1 | Protection flag |
| commitEn | output | 1 | The current write may be stored in the array |
| cmdSuppress | output | 1 | The current write is a command byte; do not program it |

## Verification
On every cycle, the embedded properties check that:
- a command byte never also commits;
- protection only ever rises after `busy` has been low;
- a disable strobe always clears the flag;
- the flag never drops without that strobe;
- the gap counter stays inside the window and a timeout returns the matcher to idle.

Some behaviour depends on whole sequences and can only be shown by the bench's scenarios. These are:
- which multi-write sequences lock, unlock a page or disable;
- that a broken sequence costs the following writes their key status;
- the exact window boundary (`WINDOW_CYC` accepted, one more rejected);
- that power reset keeps the flag.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_OPEN,
    ST_DIS3,
    ST_DIS4,
    ST_DIS5
  } seqState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic armLock;
    logic clrProt;
  } strobe_t;

  // Key-comparator results from the datapath to the control
  typedef struct packed {
    logic keyFirst;   // first key byte at the primary address
    logic keySecond;  // second key byte at the secondary address
    logic opLock;     // lock opcode at the primary address
    logic opErase;    // disable-prefix opcode at the primary address
    logic opUnlock;   // disable-final opcode at the primary address
  } match_t;

endpackage

// File: rtl/wprot_dp.sv
module wprot_dp
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] CMD_ADDR_ONE = ADDR_W'('h5555),
  parameter logic [ADDR_W-1:0] CMD_ADDR_TWO = ADDR_W'('h2AAA),
  parameter logic [7:0] KEY_FIRST = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55,
  parameter logic [7:0] OP_LOCK = 8'hA0,
  parameter logic [7:0] OP_ERASE = 8'h80,
  parameter logic [7:0] OP_UNLOCK = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              factoryRstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  input  strobe_t           strb,
  output match_t            hit,
  output logic              protOn
);

  localparam int NUM_KEYS = 5;
  localparam logic [ADDR_W-1:0] KEY_ADDR [NUM_KEYS] =
    '{CMD_ADDR_ONE, CMD_ADDR_TWO, CMD_ADDR_ONE, CMD_ADDR_ONE, CMD_ADDR_ONE};
  localparam logic [7:0] KEY_DATA [NUM_KEYS] =
    '{KEY_FIRST, KEY_SECOND, OP_LOCK, OP_ERASE, OP_UNLOCK};

  logic [NUM_KEYS-1:0] hitVec;

  for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_key
    assign hitVec[gi] = (wrAddr == KEY_ADDR[gi]) && (wrData == KEY_DATA[gi]);
  end

  assign hit = {hitVec[0], hitVec[1], hitVec[2], hitVec[3], hitVec[4]};

  logic lockPend;
  logic busyQ;
  logic busyFall;

  assign busyFall = busyQ && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      lockPend <= 1'b0;
    end else begin
      busyQ <= busy;
      if (strb.clrProt) begin
        lockPend <= 1'b0;
      end else if (strb.armLock) begin
        lockPend <= 1'b1;
      end else if (busyFall) begin
        lockPend <= 1'b0;
      end
    end
  end

  // The protection flag survives power reset; only the factory reset clears it
  always_ff @(posedge clk or negedge factoryRstN) begin
    if (!factoryRstN) begin
      protOn <= 1'b0;
    end else if (strb.clrProt) begin
      protOn <= 1'b0;
    end else if (lockPend && busyFall && rstN) begin
      protOn <= 1'b1;
    end
  end

  AST_PROT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    $rose(protOn) |-> !$past(busy)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN || !factoryRstN)
    strb.clrProt |=> !protOn); // R6

  AST_PROT_HOLDS: assert property (@(posedge clk) disable iff (!factoryRstN)
    protOn && !strb.clrProt |=> protOn); // R9

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int WINDOW_CYC = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrValid,
  input  match_t  hit,
  input  logic    protOn,
  output strobe_t strb,
  output logic    commitEn,
  output logic    cmdSuppress
);

  localparam int WIN_W = $clog2(WINDOW_CYC + 1);
  localparam logic [WIN_W-1:0] GAP_LAST = WIN_W'(WINDOW_CYC - 1);

  seqState_t state, nextState;
  logic [WIN_W-1:0] gapCnt;
  logic timeout;

  assign timeout = !wrValid && (state != ST_IDLE) && (gapCnt == GAP_LAST);

  always_comb begin
    nextState   = state;
    commitEn    = 1'b0;
    cmdSuppress = 1'b0;
    strb        = '0;
    if (wrValid) begin
      // Default: a write that breaks a sequence is handled like a plain write
      nextState = ST_IDLE;
      commitEn  = !protOn;
      unique case (state)
        ST_IDLE: if (hit.keyFirst) begin
          nextState = ST_KEY1; cmdSuppress = 1'b1; commitEn = 1'b0;
        end
        ST_KEY1: if (hit.keySecond) begin
          nextState = ST_KEY2; cmdSuppress = 1'b1; commitEn = 1'b0;
        end
        ST_KEY2: begin
          if (hit.opLock) begin
            nextState = ST_OPEN; cmdSuppress = 1'b1; commitEn = 1'b0;
            strb.armLock = 1'b1;
          end else if (hit.opErase) begin
            nextState = ST_DIS3; cmdSuppress = 1'b1; commitEn = 1'b0;
          end
        end
        ST_OPEN: begin
          nextState = ST_OPEN;
          commitEn  = 1'b1;
        end
        ST_DIS3: if (hit.keyFirst) begin
          nextState = ST_DIS4; cmdSuppress = 1'b1; commitEn = 1'b0;
        end
        ST_DIS4: if (hit.keySecond) begin
          nextState = ST_DIS5; cmdSuppress = 1'b1; commitEn = 1'b0;
        end
        ST_DIS5: if (hit.opUnlock) begin
          nextState = ST_IDLE; cmdSuppress = 1'b1; commitEn = 1'b0;
          strb.clrProt = 1'b1;
        end
        default: nextState = ST_IDLE;
      endcase
    end else if (timeout) begin
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      state <= nextState;
      if (wrValid || state == ST_IDLE || timeout) begin
        gapCnt <= '0;
      end else begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  AST_CMD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    cmdSuppress |-> !commitEn); // R2

  AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && protOn && state == ST_IDLE && !cmdSuppress |-> !commitEn); // R4

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt < WIN_W'(WINDOW_CYC)); // R8

  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    state != ST_IDLE && !wrValid && gapCnt == GAP_LAST |=> state == ST_IDLE); // R8

  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> !commitEn && !cmdSuppress); // R1

endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int WINDOW_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              factoryRstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  output logic              protOn,
  output logic              commitEn,
  output logic              cmdSuppress
);

  strobe_t strb;
  match_t  hit;

  wprot_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .factoryRstN (factoryRstN),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .busy        (busy),
    .strb        (strb),
    .hit         (hit),
    .protOn      (protOn)
  );

  wprot_ctrl #(.WINDOW_CYC(WINDOW_CYC)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrValid     (wrValid),
    .hit         (hit),
    .protOn      (protOn),
    .strb        (strb),
    .commitEn    (commitEn),
    .cmdSuppress (cmdSuppress)
  );

endmodule

// File: tb/test_wprot_seq.sv
module test_wprot_seq;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic factoryRstN = 1'b0;
  logic wrValid = 1'b0;
  logic [16:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic busy = 1'b0;
  logic protOn, commitEn, cmdSuppress;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wprot_seq #(.ADDR_W(17), .WINDOW_CYC(W)) i_wprot_seq (
    .clk(clk), .rstN(rstN), .factoryRstN(factoryRstN), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .protOn(protOn),
    .commitEn(commitEn), .cmdSuppress(cmdSuppress)
  );

  typedef struct packed {
    logic [16:0] addr;
    logic [7:0]  data;
    logic        busyP;
    logic [7:0]  idle;
    logic        expCommit;
    logic        expCmd;
    logic        expProt;
    logic [7:0]  reqNo;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{17'h00100, 8'h11, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd10}, // R10 plain
    '{17'h05555, 8'h12, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd10}, // R10 key addr
    '{17'h05555, 8'hAA, 1'b0, 8'd0,  1'b0, 1'b1, 1'b0, 8'd2},  // R2
    '{17'h02AAA, 8'h55, 1'b0, 8'd0,  1'b0, 1'b1, 1'b0, 8'd2},
    '{17'h05555, 8'hA0, 1'b1, 8'd0,  1'b0, 1'b1, 1'b1, 8'd3},  // R3
    '{17'h00300, 8'h33, 1'b0, 8'd20, 1'b1, 1'b0, 1'b1, 8'd5},  // R5
    '{17'h00300, 8'h44, 1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 8'd4},  // R4
    '{17'h05555, 8'hAA, 1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd2},
    '{17'h02AAA, 8'h55, 1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd2},
    '{17'h05555, 8'hA0, 1'b1, 8'd0,  1'b0, 1'b1, 1'b1, 8'd2},
    '{17'h00400, 8'h55, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 8'd5},  // R5 page
    '{17'h00401, 8'h56, 1'b0, 8'd20, 1'b1, 1'b0, 1'b1, 8'd5},
    '{17'h05555, 8'hAA, 1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd2},
    '{17'h01111, 8'h77, 1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 8'd7},  // R7 break
    '{17'h02AAA, 8'h55, 1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 8'd7},
    '{17'h05555, 8'hA0, 1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 8'd7},
    '{17'h05555, 8'hAA, 1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd6},  // R6 disable
    '{17'h02AAA, 8'h55, 1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd6},
    '{17'h05555, 8'h80, 1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd6},
    '{17'h05555, 8'hAA, 1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd6},
    '{17'h02AAA, 8'h55, 1'b0, 8'd0,  1'b0, 1'b1, 1'b1, 8'd6},
    '{17'h05555, 8'h20, 1'b0, 8'd0,  1'b0, 1'b1, 1'b0, 8'd6},
    '{17'h00500, 8'h99, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd10}
  };

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with wrValid low
  task automatic doWrite(input logic [16:0] a, input logic [7:0] d,
                         output logic gotCommit, output logic gotCmd);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    #2;
    gotCommit = commitEn;
    gotCmd = cmdSuppress;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic busyPulse();
    busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic c, m;
    repeat (3) @(negedge clk);
    rstN = 1'b1; factoryRstN = 1'b1;
    @(negedge clk);
    chk("R1", protOn, 1'b0, "protOn after reset");
    chk("R1", commitEn, 1'b0, "commitEn idle");
    chk("R1", cmdSuppress, 1'b0, "cmdSuppress idle");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d[v%0d]", VECS[i].reqNo, i);
      doWrite(VECS[i].addr, VECS[i].data, c, m);
      if (VECS[i].busyP) begin
        chk(tag, protOn, VECS[i].expProt && (i != 4), "protOn before busy");
        busyPulse();
      end
      repeat (VECS[i].idle) @(negedge clk);
      chk(tag, c, VECS[i].expCommit, "commitEn");
      chk(tag, m, VECS[i].expCmd, "cmdSuppress");
      chk(tag, protOn, VECS[i].expProt, "protOn");
    end

    // R3: lock stays pending while busy is held
    busy = 1'b1;
    doWrite(17'h05555, 8'hAA, c, m);
    doWrite(17'h02AAA, 8'h55, c, m);
    doWrite(17'h05555, 8'hA0, c, m);
    chk("R2", m, 1'b1, "lock opcode suppressed");
    repeat (3) @(negedge clk);
    chk("R3", protOn, 1'b0, "protOn while busy");
    busy = 1'b0;
    @(negedge clk);
    chk("R3", protOn, 1'b1, "protOn after busy falls");
    repeat (20) @(negedge clk);

    // R8: gap of exactly W cycles keeps the sequence
    doWrite(17'h05555, 8'hAA, c, m);
    repeat (W - 1) @(negedge clk);
    doWrite(17'h02AAA, 8'h55, c, m);
    chk("R8", m, 1'b1, "key at gap W");
    repeat (W - 1) @(negedge clk);
    doWrite(17'h05555, 8'hA0, c, m);
    chk("R8", m, 1'b1, "opcode at gap W");
    doWrite(17'h00600, 8'h5A, c, m);
    chk("R8", c, 1'b1, "page data after window-edge sequence");
    repeat (20) @(negedge clk);
    // R8: gap of W+1 drops it
    doWrite(17'h05555, 8'hAA, c, m);
    repeat (W) @(negedge clk);
    doWrite(17'h02AAA, 8'h55, c, m);
    chk("R8", m, 1'b0, "key at gap W+1 not a command");
    chk("R8", c, 1'b0, "key at gap W+1 not stored");

    // R9: power reset keeps protection, clears matcher
    doWrite(17'h05555, 8'hAA, c, m);
    doWrite(17'h02AAA, 8'h55, c, m);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", protOn, 1'b1, "protOn after power reset");
    doWrite(17'h05555, 8'hA0, c, m);
    chk("R9", m, 1'b0, "matcher idle after power reset");
    chk("R9", c, 1'b0, "write dropped after power reset");
    factoryRstN = 1'b0;
    @(negedge clk);
    factoryRstN = 1'b1;
    @(negedge clk);
    chk("R9", protOn, 1'b0, "protOn after factory reset");
    doWrite(17'h00700, 8'h01, c, m);
    chk("R10", c, 1'b1, "plain write commits after factory reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule